// File: doc/BRIEF.md
# Paired Scatter-Gather Descriptor Walker

This block sequences the descriptor fetches of a memory-to-memory DMA channel running in scatter-gather mode. Software loads two chain start pointers, one for the source chain and one for the destination chain, and then sets the enable bit. The walker fetches one source descriptor and one destination descriptor over a single-outstanding memory read port. It checks that their sizes agree and hands one copy command to a downstream data mover. It waits for the mover to finish, then follows both next pointers together.

Each 32-byte descriptor holds the following fields:
- a buffer address in the low 44 bits of the doubleword at offset 0;
- the byte count in bits 31:0 of the doubleword at offset 8;
- the control word in bits 63:32 of the same doubleword;
- the next-descriptor address in the low 44 bits of the doubleword at offset 16.

The doubleword at offset 24 is reserved and is never read. By convention a destination descriptor sits 32 bytes after its source descriptor. The walker itself only follows its own pointers.

Two control bits drive the walk. Bit 4 ends the walk after the pair completes. Bit 2 of the destination control word requests a completion report. Bits 1 and 0 concern the data path and are ignored here. The interrupt unit receives single-cycle pulses for descriptor completion, chain completion and the two descriptor-read error kinds. It also receives a wrapping count of reported destination completions.

Top module: `sg_pair_walker`

## Requirements
- R1: After reset, `idle` is 1, `rd_req`, `cmd_valid` and all pulse outputs are 0, and `dst_acct` is 0.
- R2: A walk starts only on a `ctl_wr` cycle with `ctl_wdata[0]`=1 while `sg_mode`=1 and the walker is idle; any other control write leaves `idle` high and issues no read.
- R3: A `ptr_wr` with `ptr_sel` 0 loads source pointer bits 31:0 and 1 loads bits 43:32 from `ptr_wdata[11:0]`; 2 and 3 do the same for the destination pointer. Pointer writes while a walk runs are ignored.
- R4: For each pair the walker reads the source descriptor at offsets +0, +8, +16 and then the destination descriptor at the same offsets. Only one read is outstanding at a time, and `rd_req` and `rd_addr` hold until `rd_ready`.
- R5: When both reads succeed and the sizes match, exactly one command is issued: `cmd_src` is the source buffer address, `cmd_dst` the destination buffer address, and `cmd_len` the size. All three hold stable until `cmd_ready`.
- R6: No read is issued between command acceptance and `mv_done`. After `mv_done` without a stop, the next pair is fetched from the two next-descriptor addresses.
- R7: If bit 4 of either control word of the pair is set, then after `mv_done` the walk ends, `chan_done` pulses for one cycle and `idle` is 1 in that same cycle.
- R8: If bit 2 of the destination control word is set, `dsc_done` pulses after `mv_done` and `dst_acct` increments by one (wrapping); bit 2 in a source control word has no effect.
- R9: If the destination size differs from the source size, `dst_rd_err` pulses, no command is issued and the walk ends.
- R10: A read response with `rd_rsp_err` during a source fetch pulses `src_rd_err`; during a destination fetch it pulses `dst_rd_err`; either way the walk ends with no further reads and no command.
- R11: A source size above 0x40000000 pulses `src_rd_err` with no command; a size of exactly 0x40000000 is accepted.
- R12: `idle` is low for the whole walk, and at most one of `chan_done`, `src_rd_err`, `dst_rd_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sg_mode | input | 1 | Scatter-gather mode selected |
| ptr_wr | input | 1 | Chain pointer word write strobe |
| ptr_sel | input | 2 | 0 src low, 1 src high, 2 dst low, 3 dst high |
| ptr_wdata | input | 32 | Pointer word data |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control data, bit 0 enable |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 44 | Memory read byte address |
| rd_ready | input | 1 | Read request accepted |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 64 | Read data doubleword |
| rd_rsp_err | input | 1 | Read response error |
| cmd_valid | output | 1 | Copy command valid |
| cmd_ready | input | 1 | Copy command accepted |
| cmd_src | output | 44 | Source buffer address |
| cmd_dst | output | 44 | Destination buffer address |
| cmd_len | output | LEN_W | Copy length in bytes |
| mv_done | input | 1 | Mover finished the current command |
| idle | output | 1 | No walk in progress |
| dsc_done | output | 1 | Destination descriptor completion pulse |
| chan_done | output | 1 | Chain finished pulse |
| src_rd_err | output | 1 | Source descriptor error pulse |
| dst_rd_err | output | 1 | Destination descriptor error or size mismatch pulse |
| dst_acct | output | ACCT_W | Count of reported destination completions |

## Verification
A wrong walk state shows at the read port within one or two cycles. A pointer advanced from the wrong next field, or a source and destination that fall out of step, produces a wrong `rd_addr` on the very next request. A mis-latched field appears as a wrong copy command as soon as `cmd_valid` rises. A stop or completion bit decoded from the wrong word shows in the cycle after `mv_done`. Depending on the fault, `chan_done` is missing or a fetch restarts, or `dsc_done` and `dst_acct` disagree with the destination bit. Error paths are visible as the wrong error pulse, or as reads and commands continuing after the error response.

// File: rtl/sgw_pkg.sv
// Shared types for the paired descriptor walker.
// Assumes 44-bit byte addresses and descriptors of four 64-bit doublewords.
package sgw_pkg;
    localparam int AW        = 44;
    localparam int DW        = 64;
    localparam int STOP_BIT  = 4;
    localparam int IRQ_BIT   = 2;

    typedef enum logic [2:0] {
        W_IDLE, W_FSRC, W_FDST, W_ISSUE, W_WAIT
    } walk_st_t;

    typedef struct packed {
        logic [AW-1:0] buf_addr;
        logic [31:0]   size;
        logic [31:0]   ctrl;
        logic [AW-1:0] next;
    } desc_t;
endpackage

// File: rtl/sgw_ptr_regs.sv
// Chain start pointer registers, written a 32-bit word at a time.
// sel[1] picks source (0) or destination (1); sel[0] picks low or high word.
// Assumes lock is high for the whole of a walk.
module sgw_ptr_regs
    import sgw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    sel,
    input  logic [31:0]   wdata,
    input  logic          lock,
    output logic [AW-1:0] src_base,
    output logic [AW-1:0] dst_base
);
    localparam int HI_W = AW - 32;

    for (genvar g = 0; g < 2; g++) begin : g_ptr
        logic [AW-1:0] r;
        // Load one word of pointer g when it is addressed and unlocked.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r <= '0;
            end else if (wr_en && !lock && (sel[1] == 1'(g))) begin
                if (sel[0]) r[AW-1:32] <= wdata[HI_W-1:0];
                else        r[31:0]    <= wdata;
            end
        end
    end

    assign src_base = g_ptr[0].r;
    assign dst_base = g_ptr[1].r;
endmodule

// File: rtl/sgw_desc_reader.sv
// Fetches the three used doublewords of one descriptor, one read at a time.
// A go pulse starts a fetch at base; done pulses once with err set if any
// response carried an error (the fetch stops at that response).
// Assumes go arrives only while no fetch is in progress.
module sgw_desc_reader
    import sgw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] base,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ready,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data,
    input  logic          rsp_err,
    output logic          done,
    output logic          err,
    output desc_t         desc
);
    localparam int WORDS = 3;
    localparam int IDX_W = $clog2(WORDS);

    logic [AW-1:0]    base_q;
    logic [IDX_W-1:0] idx;
    logic             waiting;

    // Byte address of the current doubleword.
    assign rd_addr = base_q + AW'({idx, 3'b000});

    // Request/response sequencing and field capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            idx     <= '0;
            waiting <= 1'b0;
            rd_req  <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
            desc    <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                base_q <= base;
                idx    <= '0;
                rd_req <= 1'b1;
            end else if (rd_req && rd_ready) begin
                rd_req  <= 1'b0;
                waiting <= 1'b1;
            end else if (waiting && rsp_valid) begin
                waiting <= 1'b0;
                if (rsp_err) begin
                    done <= 1'b1;
                    err  <= 1'b1;
                end else begin
                    case (idx)
                        IDX_W'(0): desc.buf_addr <= rsp_data[AW-1:0];
                        IDX_W'(1): begin
                            desc.size <= rsp_data[31:0];
                            desc.ctrl <= rsp_data[63:32];
                        end
                        default:   desc.next <= rsp_data[AW-1:0];
                    endcase
                    if (idx == IDX_W'(WORDS - 1)) begin
                        done <= 1'b1;
                        err  <= 1'b0;
                    end else begin
                        idx    <= idx + 1'b1;
                        rd_req <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sgw_acct.sv
// Wrapping counter of reported destination completions.
module sgw_acct #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Count one per increment request, wrapping at 2**W.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/sg_pair_walker.sv
// Walks a source and a destination descriptor chain in lockstep and turns
// each matched pair into one copy command for a downstream mover.
// Assumes the mover raises mv_done exactly once per accepted command, and
// the memory returns one response per accepted read.
module sg_pair_walker
    import sgw_pkg::*;
#(
    parameter int          ACCT_W  = 8,
    parameter int          LEN_W   = 31,
    parameter logic [31:0] MAX_LEN = 32'h4000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sg_mode,
    input  logic              ptr_wr,
    input  logic [1:0]        ptr_sel,
    input  logic [31:0]       ptr_wdata,
    input  logic              ctl_wr,
    input  logic [31:0]       ctl_wdata,
    output logic              rd_req,
    output logic [43:0]       rd_addr,
    input  logic              rd_ready,
    input  logic              rd_rsp_valid,
    input  logic [63:0]       rd_rsp_data,
    input  logic              rd_rsp_err,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [43:0]       cmd_src,
    output logic [43:0]       cmd_dst,
    output logic [LEN_W-1:0]  cmd_len,
    input  logic              mv_done,
    output logic              idle,
    output logic              dsc_done,
    output logic              chan_done,
    output logic              src_rd_err,
    output logic              dst_rd_err,
    output logic [ACCT_W-1:0] dst_acct
);
    walk_st_t      state;
    logic [AW-1:0] src_base, dst_base;
    logic [AW-1:0] cur_dst;
    logic [AW-1:0] go_base;
    logic          go_q;
    logic          rdr_done, rdr_err;
    desc_t         rdr_desc;
    desc_t         src_d, dst_d;
    logic          start;
    logic          pair_stop;
    logic          acct_inc;
    logic          unused_bits;

    assign idle      = (state == W_IDLE);
    assign start     = idle && ctl_wr && ctl_wdata[0] && sg_mode;
    assign pair_stop = src_d.ctrl[STOP_BIT] || dst_d.ctrl[STOP_BIT];
    assign acct_inc  = (state == W_WAIT) && mv_done && dst_d.ctrl[IRQ_BIT];

    assign cmd_valid = (state == W_ISSUE);
    assign cmd_src   = src_d.buf_addr;
    assign cmd_dst   = dst_d.buf_addr;
    assign cmd_len   = src_d.size[LEN_W-1:0];

    assign unused_bits = ^{ctl_wdata[31:1], src_d.ctrl, dst_d.ctrl,
                           dst_d.size, src_d.size[31:LEN_W]};

    sgw_ptr_regs u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ptr_wr),
        .sel      (ptr_sel),
        .wdata    (ptr_wdata),
        .lock     (!idle),
        .src_base (src_base),
        .dst_base (dst_base)
    );

    sgw_desc_reader u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go_q),
        .base      (go_base),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_ready  (rd_ready),
        .rsp_valid (rd_rsp_valid),
        .rsp_data  (rd_rsp_data),
        .rsp_err   (rd_rsp_err),
        .done      (rdr_done),
        .err       (rdr_err),
        .desc      (rdr_desc)
    );

    sgw_acct #(.W(ACCT_W)) u_acct (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (acct_inc),
        .count (dst_acct)
    );

    // Walk sequencer: fetch source, fetch destination, issue, wait, repeat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= W_IDLE;
            cur_dst    <= '0;
            go_base    <= '0;
            go_q       <= 1'b0;
            src_d      <= '0;
            dst_d      <= '0;
            dsc_done   <= 1'b0;
            chan_done  <= 1'b0;
            src_rd_err <= 1'b0;
            dst_rd_err <= 1'b0;
        end else begin
            go_q       <= 1'b0;
            dsc_done   <= 1'b0;
            chan_done  <= 1'b0;
            src_rd_err <= 1'b0;
            dst_rd_err <= 1'b0;
            case (state)
                W_IDLE: if (start) begin
                    cur_dst <= dst_base;
                    go_base <= src_base;
                    go_q    <= 1'b1;
                    state   <= W_FSRC;
                end
                W_FSRC: if (rdr_done) begin
                    if (rdr_err || (rdr_desc.size > MAX_LEN)) begin
                        src_rd_err <= 1'b1;
                        state      <= W_IDLE;
                    end else begin
                        src_d   <= rdr_desc;
                        go_base <= cur_dst;
                        go_q    <= 1'b1;
                        state   <= W_FDST;
                    end
                end
                W_FDST: if (rdr_done) begin
                    if (rdr_err || (rdr_desc.size != src_d.size)) begin
                        dst_rd_err <= 1'b1;
                        state      <= W_IDLE;
                    end else begin
                        dst_d <= rdr_desc;
                        state <= W_ISSUE;
                    end
                end
                W_ISSUE: if (cmd_ready) state <= W_WAIT;
                W_WAIT: if (mv_done) begin
                    dsc_done <= dst_d.ctrl[IRQ_BIT];
                    if (pair_stop) begin
                        chan_done <= 1'b1;
                        state     <= W_IDLE;
                    end else begin
                        cur_dst <= dst_d.next;
                        go_base <= src_d.next;
                        go_q    <= 1'b1;
                        state   <= W_FSRC;
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sg_pair_walker_chk.sv
// Port-level protocol checker for the paired descriptor walker, bound to it.
module sg_pair_walker_chk #(
    parameter int          ACCT_W  = 8,
    parameter int          LEN_W   = 31,
    parameter logic [31:0] MAX_LEN = 32'h4000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [43:0]       rd_addr,
    input logic              rd_ready,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [43:0]       cmd_src,
    input logic [43:0]       cmd_dst,
    input logic [LEN_W-1:0]  cmd_len,
    input logic              idle,
    input logic              dsc_done,
    input logic              chan_done,
    input logic              src_rd_err,
    input logic              dst_rd_err,
    input logic [ACCT_W-1:0] dst_acct
);
    logic past_ok;

    // Marks cycles where the previous sample was taken after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!rd_req && !cmd_valid));

    assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));

    assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_src) && $stable(cmd_dst) && $stable(cmd_len)));

    assert_end_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chan_done |-> idle);

    assert_acct_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && dsc_done) |-> (dst_acct == ACCT_W'($past(dst_acct) + 1'b1)));

    assert_acct_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !dsc_done) |-> (dst_acct == $past(dst_acct)));

    assert_err_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd_err || dst_rd_err) |-> idle);

    assert_len_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_len <= MAX_LEN[LEN_W-1:0]));

    assert_end_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chan_done, src_rd_err, dst_rd_err}));
endmodule

bind sg_pair_walker sg_pair_walker_chk #(
    .ACCT_W  (ACCT_W),
    .LEN_W   (LEN_W),
    .MAX_LEN (MAX_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_ready   (rd_ready),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_src    (cmd_src),
    .cmd_dst    (cmd_dst),
    .cmd_len    (cmd_len),
    .idle       (idle),
    .dsc_done   (dsc_done),
    .chan_done  (chan_done),
    .src_rd_err (src_rd_err),
    .dst_rd_err (dst_rd_err),
    .dst_acct   (dst_acct)
);

// File: tb/sg_pair_walker_bench.sv
// Bench: memory and mover models at the negative edge, a vector table of
// chains, then directed corner cases.
module sg_pair_walker_bench;
    localparam int ACCT_W = 8;
    localparam int LEN_W  = 31;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sg_mode = 1'b1;
    logic              ptr_wr = 1'b0;
    logic [1:0]        ptr_sel = '0;
    logic [31:0]       ptr_wdata = '0;
    logic              ctl_wr = 1'b0;
    logic [31:0]       ctl_wdata = '0;
    logic              rd_req;
    logic [43:0]       rd_addr;
    logic              rd_ready = 1'b1;
    logic              rd_rsp_valid = 1'b0;
    logic [63:0]       rd_rsp_data = '0;
    logic              rd_rsp_err = 1'b0;
    logic              cmd_valid;
    logic              cmd_ready = 1'b1;
    logic [43:0]       cmd_src, cmd_dst;
    logic [LEN_W-1:0]  cmd_len;
    logic              mv_done = 1'b0;
    logic              idle, dsc_done, chan_done, src_rd_err, dst_rd_err;
    logic [ACCT_W-1:0] dst_acct;

    always #5 clk = ~clk;

    sg_pair_walker u_sg_pair_walker (
        .clk(clk), .rst_n(rst_n), .sg_mode(sg_mode),
        .ptr_wr(ptr_wr), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_src(cmd_src),
        .cmd_dst(cmd_dst), .cmd_len(cmd_len), .mv_done(mv_done),
        .idle(idle), .dsc_done(dsc_done), .chan_done(chan_done),
        .src_rd_err(src_rd_err), .dst_rd_err(dst_rd_err), .dst_acct(dst_acct)
    );

    // ---------------- models ----------------
    logic [63:0] mem [0:511];
    logic [43:0] err_addr = '1;
    logic        pend = 1'b0;
    logic [43:0] pend_addr = '0;
    logic [43:0] rd_log [0:7];
    logic [43:0] c_src [0:3];
    logic [43:0] c_dst [0:3];
    logic [LEN_W-1:0] c_len [0:3];
    int n_rd = 0, n_cmd = 0, mv_cnt = 0, mv_delay = 2, early_rd = 0;
    int n_dsc = 0, n_chan = 0, n_serr = 0, n_derr = 0;
    int n_checks = 0, n_err = 0;
    logic [ACCT_W-1:0] exp_acct = '0;

    // Memory responder, mover and pulse monitor, all away from the active edge.
    always @(negedge clk) begin
        rd_rsp_valid = 1'b0;
        rd_rsp_err   = 1'b0;
        if (pend) begin
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = mem[pend_addr[11:3]];
            rd_rsp_err   = (pend_addr == err_addr);
            pend = 1'b0;
        end
        mv_done = 1'b0;
        if (mv_cnt != 0) begin
            mv_cnt = mv_cnt - 1;
            if (mv_cnt == 0) mv_done = 1'b1;
        end
        if (rd_req) begin
            pend = 1'b1;
            pend_addr = rd_addr;
            if (n_rd < 8) rd_log[n_rd] = rd_addr;
            n_rd++;
            if (mv_cnt != 0) early_rd++;
        end
        if (cmd_valid && cmd_ready) begin
            if (n_cmd < 4) begin
                c_src[n_cmd] = cmd_src;
                c_dst[n_cmd] = cmd_dst;
                c_len[n_cmd] = cmd_len;
            end
            n_cmd++;
            mv_cnt = mv_delay;
        end
        if (dsc_done)   n_dsc++;
        if (chan_done)  n_chan++;
        if (src_rd_err) n_serr++;
        if (dst_rd_err) n_derr++;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_ptr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        ptr_wr = 1'b1; ptr_sel = sel; ptr_wdata = d;
        @(negedge clk);
        ptr_wr = 1'b0;
    endtask

    task automatic put_desc(input logic [43:0] a, input logic [43:0] bufa,
                            input logic [31:0] size, input logic [31:0] ctrl,
                            input logic [43:0] nxt);
        mem[a[11:3]]        = 64'(bufa);
        mem[a[11:3] + 9'd1] = {ctrl, size};
        mem[a[11:3] + 9'd2] = 64'(nxt);
    endtask

    task automatic clear_counts();
        n_rd = 0; n_cmd = 0; n_dsc = 0; n_chan = 0; n_serr = 0; n_derr = 0;
    endtask

    task automatic start_walk(input logic [31:0] d);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (!idle && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic set_ptrs(input logic [31:0] s, input logic [31:0] d);
        wr_ptr(2'd0, s); wr_ptr(2'd1, 32'h0);
        wr_ptr(2'd2, d); wr_ptr(2'd3, 32'h0);
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [1:0]  n;
        logic [2:0]  comp;
        logic [2:0]  scomp;
        logic        stop_src;
        logic [31:0] size;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'd1, 3'b001, 3'b000, 1'b0, 32'h0000_0040},
        '{2'd3, 3'b101, 3'b010, 1'b0, 32'h0000_0010},
        '{2'd2, 3'b000, 3'b011, 1'b1, 32'h3FFF_FFFF},
        '{2'd3, 3'b111, 3'b000, 1'b1, 32'h0000_0001},
        '{2'd2, 3'b010, 3'b000, 1'b0, 32'h0000_0000}
    };

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 idle", 64'(idle), 64'd1);
        chk("R1 rd_req", 64'(rd_req), 64'd0);
        chk("R1 cmd_valid", 64'(cmd_valid), 64'd0);
        chk("R1 pulses", 64'({dsc_done, chan_done, src_rd_err, dst_rd_err}), 64'd0);
        chk("R1 dst_acct", 64'(dst_acct), 64'd0);

        // Vector walk: R5 R6 R7 R8 R11 R12
        for (int v = 0; v < 5; v++) begin
            int nd;
            int exp_d;
            nd = int'(VECS[v].n);
            exp_d = 0;
            for (int i = 0; i < nd; i++) begin
                logic [43:0] sa, da;
                logic [31:0] cs, cd;
                logic last;
                sa = 44'(32'h100 + i * 32'h40);
                da = sa + 44'h20;
                last = (i == nd - 1);
                cs = 32'h3 | (VECS[v].scomp[i] ? 32'h4 : 32'h0)
                     | ((last && VECS[v].stop_src) ? 32'h10 : 32'h0);
                cd = (VECS[v].comp[i] ? 32'h4 : 32'h0)
                     | ((last && !VECS[v].stop_src) ? 32'h10 : 32'h0);
                if (VECS[v].comp[i]) exp_d++;
                put_desc(sa, 44'h0AB_0000_0000 + 44'(i * 32'h1000),
                         VECS[v].size + 32'(i), cs, sa + 44'h40);
                put_desc(da, 44'h0CD_0000_0000 + 44'(i * 32'h1000),
                         VECS[v].size + 32'(i), cd, da + 44'h40);
            end
            set_ptrs(32'h100, 32'h120);
            clear_counts();
            start_walk(32'h1);
            chk("R12 idle low in walk", 64'(idle), 64'd0);
            wait_idle();
            chk("R5 command count", 64'(n_cmd), 64'(nd));
            for (int i = 0; i < nd; i++) begin
                chk("R6 R5 cmd_src", 64'(c_src[i]), 64'(44'h0AB_0000_0000 + 44'(i * 32'h1000)));
                chk("R5 cmd_dst", 64'(c_dst[i]), 64'(44'h0CD_0000_0000 + 44'(i * 32'h1000)));
                chk("R11 R5 cmd_len", 64'(c_len[i]), 64'(VECS[v].size + 32'(i)));
            end
            chk("R7 chan_done", 64'(n_chan), 64'd1);
            chk("R8 dsc_done count", 64'(n_dsc), 64'(exp_d));
            exp_acct = exp_acct + ACCT_W'(exp_d);
            chk("R8 dst_acct", 64'(dst_acct), 64'(exp_acct));
            chk("R12 no error pulses", 64'(n_serr + n_derr), 64'd0);
        end

        // R4: read order and offsets, one pair
        put_desc(44'h800, 44'h111, 32'd8, 32'h10, 44'h0);
        put_desc(44'h820, 44'h222, 32'd8, 32'h10, 44'h0);
        set_ptrs(32'h800, 32'h820);
        clear_counts();
        start_walk(32'h1);
        wait_idle();
        chk("R4 read count", 64'(n_rd), 64'd6);
        for (int k = 0; k < 3; k++) begin
            chk("R4 src read addr", 64'(rd_log[k]), 64'(44'h800 + 44'(8 * k)));
            chk("R4 dst read addr", 64'(rd_log[k + 3]), 64'(44'h820 + 44'(8 * k)));
        end

        // R3: high pointer words
        wr_ptr(2'd1, 32'h5);
        wr_ptr(2'd3, 32'h7);
        clear_counts();
        start_walk(32'h1);
        wait_idle();
        chk("R3 src high word", 64'(rd_log[0]), 64'(44'h005_0000_0800));
        chk("R3 dst high word", 64'(rd_log[3]), 64'(44'h007_0000_0820));
        wr_ptr(2'd1, 32'h0);
        wr_ptr(2'd3, 32'h0);

        // R3 + R6: pointer write ignored while busy; no reads during mover wait
        mv_delay = 30;
        early_rd = 0;
        clear_counts();
        start_walk(32'h1);
        repeat (4) @(negedge clk);
        wr_ptr(2'd0, 32'h900);
        wait_idle();
        chk("R6 no read during mover wait", 64'(early_rd), 64'd0);
        clear_counts();
        start_walk(32'h1);
        wait_idle();
        chk("R3 busy write ignored", 64'(rd_log[0]), 64'(44'h800));
        mv_delay = 2;

        // R9: size mismatch
        put_desc(44'h820, 44'h222, 32'd9, 32'h10, 44'h0);
        clear_counts();
        start_walk(32'h1);
        wait_idle();
        chk("R9 dst_rd_err", 64'(n_derr), 64'd1);
        chk("R9 no command", 64'(n_cmd), 64'd0);
        chk("R9 no chan_done", 64'(n_chan), 64'd0);
        put_desc(44'h820, 44'h222, 32'd8, 32'h10, 44'h0);

        // R10: source read error
        err_addr = 44'h808;
        clear_counts();
        start_walk(32'h1);
        wait_idle();
        chk("R10 src_rd_err", 64'(n_serr), 64'd1);
        chk("R10 src err no dst err", 64'(n_derr), 64'd0);
        chk("R10 src err reads", 64'(n_rd), 64'd2);
        chk("R10 src err no command", 64'(n_cmd), 64'd0);

        // R10: destination read error
        err_addr = 44'h830;
        clear_counts();
        start_walk(32'h1);
        wait_idle();
        chk("R10 dst_rd_err", 64'(n_derr), 64'd1);
        chk("R10 dst err no src err", 64'(n_serr), 64'd0);
        chk("R10 dst err no command", 64'(n_cmd), 64'd0);
        err_addr = '1;

        // R11: oversize source
        put_desc(44'h800, 44'h111, 32'h4000_0001, 32'h10, 44'h0);
        put_desc(44'h820, 44'h222, 32'h4000_0001, 32'h10, 44'h0);
        clear_counts();
        start_walk(32'h1);
        wait_idle();
        chk("R11 oversize src_rd_err", 64'(n_serr), 64'd1);
        chk("R11 oversize no command", 64'(n_cmd), 64'd0);

        // R2: start ignored without sg_mode or without bit 0
        sg_mode = 1'b0;
        clear_counts();
        start_walk(32'h1);
        repeat (10) @(negedge clk);
        chk("R2 no sg_mode idle", 64'(idle), 64'd1);
        chk("R2 no sg_mode reads", 64'(n_rd), 64'd0);
        sg_mode = 1'b1;
        start_walk(32'h2);
        repeat (10) @(negedge clk);
        chk("R2 bit0 clear idle", 64'(idle), 64'd1);
        chk("R2 bit0 clear reads", 64'(n_rd), 64'd0);
        chk("R8 acct unchanged", 64'(dst_acct), 64'(exp_acct));

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule